// File: doc/BRIEF.md
# Programmable Clock Channel Divider

This block divides a fast input clock for one output channel. Two count fields set how long the output stays high and how long it stays low, each as a count minus one, so the high and low times can differ. A shared active-low synchronization input holds every participating channel at a chosen starting level. When that input is released, each channel waits its own phase offset and then starts counting, so channels with equal settings produce edges at the same time.

A channel can leave the shared synchronization. It then parks its output at a static level chosen by a force bit. A bypass bit sends the input clock straight to the output. The reset value of the bypass bit is a per-instance parameter. Count, phase and start-level writes first go into a staging copy. The staging copy is applied only while synchronization is held, or at the end of a full output period. A write therefore never cuts a phase short.

Top module: `chdiv_channel`

## Requirements
- R1: A write takes place on a rising clock edge when `cfg_we` is 1. With `cfg_addr`=0, bits [3:0] are the high count H and bits [7:4] are the low count L. With `cfg_addr`=1, bits [3:0] are the phase offset P, bit 4 selects start high, bit 5 is the force level, bit 6 ignores synchronization and bit 7 selects bypass.
- R2: After reset all fields are 0, and bypass equals the parameter `BYPASS_RST`. With bypass 0 the output is low after reset; with bypass 1 the output follows the input clock.
- R3: In steady counting, every high phase lasts H+1 input clock cycles.
- R4: In steady counting, every low phase lasts L+1 input clock cycles.
- R5: When synchronization is released, the first output phase has the level given by the start-high bit: 0 for low, 1 for high.
- R6: The output keeps the start level for P+N+1 cycles. The count runs from the last rising edge at which `sync_n` was sampled low to the first transition. N is the count field of the start level (H if it starts high, L if it starts low).
- R7: While `sync_n` is 0 and the ignore bit is 0, the counters are held and the output stays at the start level.
- R8: A change of H or L made while counting first takes effect in the phase after the end of the current full period. No phase of intermediate length is produced.
- R9: With the ignore bit set, `sync_n` has no effect and the output holds the force level, 0 for low and 1 for high.
- R10: With bypass set, the output equals the input clock, whatever the other fields are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_in | input | 1 | Fast input clock being divided |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sync_n | input | 1 | Shared active-low synchronization, synchronous to clk_in |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 1 | Selects the count word (0) or the control word (1) |
| cfg_wdata | input | 8 | Configuration write data |
| clk_out | output | 1 | Divided, forced or bypassed output clock |

## Verification
The hardest case to reach is a count change that arrives in the middle of a running period, because the new value must not shorten the phase in progress. The stimulus watches the output and waits for the first high sample after release. It then writes new counts during that high phase and expects one full old period followed by phases of the new lengths. Phase offset and start level are swept together with several count pairs, so that the release-to-first-edge delay is measured for each combination.

// File: rtl/chdiv_pkg.sv
package chdiv_pkg;
  parameter int unsigned CW = 4;
  localparam int unsigned DW = 2 * CW;

  localparam int unsigned START_BIT  = CW;
  localparam int unsigned FORCE_BIT  = CW + 1;
  localparam int unsigned IGNORE_BIT = CW + 2;
  localparam int unsigned BYPASS_BIT = CW + 3;

  typedef struct packed {
    logic [CW-1:0] hi_cnt;
    logic [CW-1:0] lo_cnt;
    logic [CW-1:0] ph_off;
    logic          start_hi;
  } timing_t;
endpackage

// File: rtl/chdiv_rst_sync.sv
module chdiv_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      sh_q <= '0;
    end else begin
      sh_q <= sh_d;
    end
  end

  assign srst_n = sh_q[STAGES-1];
endmodule

// File: rtl/chdiv_cfg.sv
module chdiv_cfg
  import chdiv_pkg::*;
#(
  parameter bit BYPASS_RST = 1'b0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic          cfg_addr,
  input  logic [DW-1:0] cfg_wdata,
  output timing_t       stg_q,
  output logic          ignore_q,
  output logic          force_q,
  output logic          bypass_q
);
  timing_t stg_d;
  logic    ignore_d, force_d, bypass_d;
  logic    wr_cnt_en, wr_ctl_en;

  assign wr_cnt_en = cfg_we && !cfg_addr;
  assign wr_ctl_en = cfg_we &&  cfg_addr;

  always_comb begin
    stg_d    = stg_q;
    ignore_d = ignore_q;
    force_d  = force_q;
    bypass_d = bypass_q;
    if (wr_cnt_en) begin
      stg_d.hi_cnt = cfg_wdata[CW-1:0];
      stg_d.lo_cnt = cfg_wdata[2*CW-1:CW];
    end
    if (wr_ctl_en) begin
      stg_d.ph_off   = cfg_wdata[CW-1:0];
      stg_d.start_hi = cfg_wdata[START_BIT];
      force_d        = cfg_wdata[FORCE_BIT];
      ignore_d       = cfg_wdata[IGNORE_BIT];
      bypass_d       = cfg_wdata[BYPASS_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_q    <= '0;
      ignore_q <= 1'b0;
      force_q  <= 1'b0;
      bypass_q <= BYPASS_RST;
    end else if (cfg_we) begin
      stg_q    <= stg_d;
      ignore_q <= ignore_d;
      force_q  <= force_d;
      bypass_q <= bypass_d;
    end
  end
endmodule

// File: rtl/chdiv_core.sv
module chdiv_core
  import chdiv_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hold,
  input  timing_t       stg,
  output timing_t       act_q,
  output logic [CW-1:0] cnt_q,
  output logic [CW-1:0] dly_q,
  output logic          lvl_q
);
  timing_t       act_d;
  logic [CW-1:0] cnt_d, dly_d, lim;
  logic          lvl_d;
  logic          at_end;
  logic          period_end;

  // terminal count of the phase now on the output
  assign lim        = lvl_q ? act_q.hi_cnt : act_q.lo_cnt;
  assign at_end     = (dly_q == '0) && (cnt_q == lim);
  // second phase of the period finishing: safe point to adopt staging
  assign period_end = at_end && (lvl_q != act_q.start_hi);

  always_comb begin
    act_d = act_q;
    cnt_d = cnt_q;
    dly_d = dly_q;
    lvl_d = lvl_q;
    if (hold) begin
      act_d = stg;
      cnt_d = '0;
      dly_d = stg.ph_off;
      lvl_d = stg.start_hi;
    end else if (dly_q != '0) begin
      dly_d = dly_q - 1'b1;
    end else if (period_end) begin
      act_d = stg;
      cnt_d = '0;
      lvl_d = stg.start_hi;
    end else if (at_end) begin
      cnt_d = '0;
      lvl_d = ~lvl_q;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= '0;
      cnt_q <= '0;
      dly_q <= '0;
      lvl_q <= 1'b0;
    end else begin
      act_q <= act_d;
      cnt_q <= cnt_d;
      dly_q <= dly_d;
      lvl_q <= lvl_d;
    end
  end
endmodule

// File: rtl/chdiv_outsel.sv
module chdiv_outsel (
  input  logic clk_in,
  input  logic bypass,
  input  logic ignore,
  input  logic force_lvl,
  input  logic lvl,
  output logic clk_out
);
  always_comb begin
    if (bypass) begin
      clk_out = clk_in;
    end else if (ignore) begin
      clk_out = force_lvl;
    end else begin
      clk_out = lvl;
    end
  end
endmodule

// File: rtl/chdiv_channel.sv
module chdiv_channel
  import chdiv_pkg::*;
#(
  parameter bit          BYPASS_RST = 1'b0,
  parameter int unsigned RST_STAGES = 2
) (
  input  logic          clk_in,
  input  logic          rst_n,
  input  logic          sync_n,
  input  logic          cfg_we,
  input  logic          cfg_addr,
  input  logic [DW-1:0] cfg_wdata,
  output logic          clk_out
);
  logic          rst_int_n;
  timing_t       stg_q, act_q;
  logic          ignore_q, force_q, bypass_q;
  logic [CW-1:0] cnt_q, dly_q;
  logic          lvl_q;
  logic          hold;

  chdiv_rst_sync #(.STAGES(RST_STAGES)) rst_sync_i (
    .clk    (clk_in),
    .arst_n (rst_n),
    .srst_n (rst_int_n)
  );

  chdiv_cfg #(.BYPASS_RST(BYPASS_RST)) cfg_i (
    .clk       (clk_in),
    .rst_n     (rst_int_n),
    .cfg_we    (cfg_we),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .stg_q     (stg_q),
    .ignore_q  (ignore_q),
    .force_q   (force_q),
    .bypass_q  (bypass_q)
  );

  assign hold = !sync_n && !ignore_q;

  chdiv_core core_i (
    .clk   (clk_in),
    .rst_n (rst_int_n),
    .hold  (hold),
    .stg   (stg_q),
    .act_q (act_q),
    .cnt_q (cnt_q),
    .dly_q (dly_q),
    .lvl_q (lvl_q)
  );

  chdiv_outsel outsel_i (
    .clk_in    (clk_in),
    .bypass    (bypass_q),
    .ignore    (ignore_q),
    .force_lvl (force_q),
    .lvl       (lvl_q),
    .clk_out   (clk_out)
  );
endmodule

// File: rtl/chdiv_channel_chk.sv
module chdiv_channel_chk
  import chdiv_pkg::*;
(
  input logic          clk,
  input logic          rst_n,
  input logic          hold,
  input logic          cfg_we,
  input logic          ignore_q,
  input logic          bypass_q,
  input logic          clk_out,
  input timing_t       act_q,
  input logic [CW-1:0] cnt_q,
  input logic [CW-1:0] dly_q,
  input logic          lvl_q
);
  // R3 and R4: count never passes the terminal value of the current phase
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= (lvl_q ? act_q.hi_cnt : act_q.lo_cnt));

  // R6
  phase_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dly_q != '0 && !hold) |=> $stable(lvl_q));

  // R7
  hold_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(hold) && $past(hold, 2) && !$past(cfg_we, 2)) |-> $stable(lvl_q));

  // R8
  adopt_point_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q != $past(act_q)) |-> ($past(hold) || ($past(dly_q) == '0 && cnt_q == '0)));

  // R9
  parked_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ignore_q && !bypass_q && $past(ignore_q && !bypass_q) && !$past(cfg_we))
      |-> $stable(clk_out));
endmodule

bind chdiv_channel chdiv_channel_chk chk_i (
  .clk      (clk_in),
  .rst_n    (rst_int_n),
  .hold     (hold),
  .cfg_we   (cfg_we),
  .ignore_q (ignore_q),
  .bypass_q (bypass_q),
  .clk_out  (clk_out),
  .act_q    (act_q),
  .cnt_q    (cnt_q),
  .dly_q    (dly_q),
  .lvl_q    (lvl_q)
);

// File: tb/chdiv_channel_tb_top.sv
module chdiv_channel_tb_top;
  logic       clk;
  logic       rst_n;
  logic       sync_n;
  logic       cfg_we;
  logic       cfg_addr;
  logic [7:0] cfg_wdata;
  logic       clk_out;
  logic       clk_out_byp;

  int n_tests;
  int n_fail;
  int exp_q[$];

  chdiv_channel #(.BYPASS_RST(1'b0)) dut_i (
    .clk_in (clk), .rst_n (rst_n), .sync_n (sync_n),
    .cfg_we (cfg_we), .cfg_addr (cfg_addr), .cfg_wdata (cfg_wdata),
    .clk_out (clk_out)
  );

  chdiv_channel #(.BYPASS_RST(1'b1)) dut_byp_i (
    .clk_in (clk), .rst_n (rst_n), .sync_n (sync_n),
    .cfg_we (1'b0), .cfg_addr (1'b0), .cfg_wdata (8'h00),
    .clk_out (clk_out_byp)
  );

  initial begin
    clk = 1'b0;
    forever #4 clk = ~clk;
  end

  task automatic check(input string req, input int act, input int exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
  endtask

  // monitor: measures run lengths after a release and scores them
  initial begin
    logic armed, prev_s, cur, s;
    int   run;
    armed  = 1'b0;
    prev_s = 1'b0;
    cur    = 1'b0;
    run    = 0;
    forever begin
      @(negedge clk);
      #1;
      s = clk_out;
      if (!armed && !prev_s && sync_n && exp_q.size() > 0) begin
        armed = 1'b1;
        cur   = s;
        run   = 1;
      end else if (armed) begin
        if (s == cur) begin
          run++;
        end else begin
          check("R3 R4 R5 R6 R8 level*1000+width", int'(cur) * 1000 + run, exp_q.pop_front());
          cur = s;
          run = 1;
          if (exp_q.size() == 0) armed = 1'b0;
        end
      end
      prev_s = sync_n;
    end
  end

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk);
    cfg_we    = 1'b1;
    cfg_addr  = a;
    cfg_wdata = d;
    @(negedge clk);
    cfg_we    = 1'b0;
  endtask

  task automatic drain();
    for (int i = 0; i < 2000 && exp_q.size() > 0; i++) @(negedge clk);
    check("R3 R4 expected phases all seen", exp_q.size(), 0);
    exp_q.delete();
  endtask

  // driver: program under hold, push expected phases, release
  task automatic run_case(input int h, input int l, input int p, input int s, input int n);
    int lim_s, lim_o;
    logic [7:0] cnt_w, ctl_w;
    lim_s = s ? h : l;
    lim_o = s ? l : h;
    cnt_w = {l[3:0], h[3:0]};
    ctl_w = {3'b000, s[0], p[3:0]};
    @(negedge clk);
    sync_n = 1'b0;
    wr(1'b0, cnt_w);
    wr(1'b1, ctl_w);
    repeat (2) @(negedge clk);
    #1;
    check("R7 held at start level", int'(clk_out), s);
    exp_q.push_back(s * 1000 + p + lim_s + 1);
    for (int i = 1; i < n; i++) begin
      if (i % 2 == 1) exp_q.push_back((1 - s) * 1000 + lim_o + 1);
      else            exp_q.push_back(s * 1000 + lim_s + 1);
    end
    @(negedge clk);
    sync_n = 1'b1;
    drain();
  endtask

  initial begin
    n_tests   = 0;
    n_fail    = 0;
    rst_n     = 1'b0;
    sync_n    = 1'b0;
    cfg_we    = 1'b0;
    cfg_addr  = 1'b0;
    cfg_wdata = 8'h00;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    // R2: divided channel low after reset
    check("R2 reset output", int'(clk_out), 0);
    // R2: bypass-by-default instance follows the clock
    @(posedge clk); #2;
    check("R2 bypass reset high", int'(clk_out_byp), 1);
    @(negedge clk); #2;
    check("R2 bypass reset low", int'(clk_out_byp), 0);
    // R7: held low across several cycles
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); #1;
      check("R7 hold keeps output", int'(clk_out), 0);
    end

    // R1 R3 R4 R5 R6 sweeps
    run_case(0, 0, 0, 0, 6);
    run_case(3, 1, 2, 0, 5);
    run_case(2, 5, 4, 1, 5);
    run_case(7, 0, 1, 1, 5);
    run_case(15, 15, 3, 0, 4);
    run_case(0, 9, 15, 1, 5);
    run_case(4, 4, 0, 1, 4);

    // R8: count change while running lands at the period end
    @(negedge clk);
    sync_n = 1'b0;
    wr(1'b0, {4'd2, 4'd5});
    wr(1'b1, 8'h00);
    repeat (2) @(negedge clk);
    exp_q.push_back(0 * 1000 + 3);
    exp_q.push_back(1 * 1000 + 6);
    @(negedge clk);
    sync_n = 1'b1;
    for (int i = 0; i < 50; i++) begin
      @(negedge clk); #1;
      if (clk_out) break;
    end
    wr(1'b0, {4'd3, 4'd1});
    exp_q.push_back(0 * 1000 + 4);
    exp_q.push_back(1 * 1000 + 2);
    exp_q.push_back(0 * 1000 + 4);
    drain();

    // R9: ignore sync, park high then low while sync toggles
    wr(1'b1, 8'b0110_0000);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      sync_n = i[0];
      #1;
      check("R9 forced high", int'(clk_out), 1);
    end
    wr(1'b1, 8'b0100_0000);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      sync_n = ~i[0];
      #1;
      check("R9 forced low", int'(clk_out), 0);
    end

    // R10: bypass, alone and over a parked setting
    wr(1'b1, 8'b1000_0000);
    for (int i = 0; i < 3; i++) begin
      @(posedge clk); #2;
      check("R10 bypass high", int'(clk_out), 1);
      @(negedge clk); #2;
      check("R10 bypass low", int'(clk_out), 0);
    end
    wr(1'b1, 8'b1110_0000);
    for (int i = 0; i < 3; i++) begin
      @(posedge clk); #2;
      check("R10 bypass over force high", int'(clk_out), 1);
      @(negedge clk); #2;
      check("R10 bypass over force low", int'(clk_out), 0);
    end

    summary();
    $finish;
  end

  initial begin
    #(200000 * 8);
    n_tests++;
    n_fail++;
    $display("FAIL R2 watchdog: got 0 expected 1");
    summary();
    $finish;
  end
endmodule